// File: doc/BRIEF.md
# Multiplexer Channel Scan Sequencer

This block decides, one conversion phase at a time, which input of an eight-input converter front end is acquired next. It reads a 14-bit configuration word and a strobe that marks the start of each conversion phase. It drives a channel select for the analog multiplexer, and a tag that labels the data word the converter returns one phase later. The multiplexer, the converter and the temperature sensor are outside this block. Only the select and tag outputs represent them here.

The block can scan single-ended inputs one by one. It can also scan differential pairs, where the positive input is even and the negative input is the next odd one. A temperature slot may be added at the end of each pass. With the sequencer off, it selects one fixed channel taken straight from the configuration. A configuration word is written at any time during a phase and is held as pending. It takes effect only at the next phase strobe. If that word alters the pairing or the end point, the scan starts again from input 0.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset `acq_valid` and `tag_valid` are 0. They stay 0 across phase strobes until a configuration word has been written and applied.
- R2: A word written with `cfg_wr` is applied at the first `phase_stb` in a later cycle. A write in the same cycle as a strobe waits for the following strobe, and a write between strobes does not change any output.
- R3: In single-ended scan (bit 11 = 1), the selection steps 0, 1, 2, … up to the last-channel field in bits 9:7, and then wraps.
- R4: In pair scan (bit 11 = 0), `acq_pair` is 1 and the selection steps by two over even channels 0, 2, 4, 6. The end point is the last-channel field with bit 0 cleared, so 6 and 7 both scan four pairs.
- R5: Mode field bits 2:1 = 01 scans with a temperature slot (`acq_temp` = 1, `acq_chan` = 0) after the end point and before the wrap to 0. Mode 10 scans with no temperature slot.
- R6: Applying a word that changes bit 11 or bits 9:7, or that switches the sequencer on, makes the newly acquired selection input 0. Changing only other bits, such as the mode field between 01 and 10, lets the scan carry on in order.
- R7: With mode 00 or 11 the sequencer is off. Each strobe selects the last-channel field directly (bit 0 cleared in pair mode), with `acq_temp` = 0.
- R8: At every strobe the tag outputs take the acquisition outputs of the phase that is ending, so `tag_valid` first rises one phase after `acq_valid`.
- R9: Acquisition and tag outputs change only in the cycle after a `phase_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Capture `cfg_word` as the pending configuration |
| cfg_word | input | 14 | Configuration: bit 11 single/pair, bits 9:7 last channel, bits 2:1 mode |
| phase_stb | input | 1 | One-cycle pulse at the start of each conversion phase |
| acq_valid | output | 1 | Acquisition selection is meaningful |
| acq_chan | output | 3 | Channel (positive input in pair mode) acquired this phase |
| acq_pair | output | 1 | Selection is a differential pair |
| acq_temp | output | 1 | Temperature slot selected |
| tag_valid | output | 1 | Result tag is meaningful |
| tag_chan | output | 3 | Channel of the result leaving the converter |
| tag_pair | output | 1 | Result came from a pair |
| tag_temp | output | 1 | Result is the temperature reading |

## Verification
The assertions take the strobe to be a single-cycle pulse. They also take reset to be held low for at least one clock edge at start-up, so that the stability and restart properties begin from a defined state. The stimulus sends a strobe after zero to two idle cycles. Configuration writes are rare and random, and some of them land in the same cycle as a strobe. Directed phases walk the full single and pair passes and the mid-scan edits.

// File: rtl/chan_scan_pkg.sv
// Shared types and configuration decode for the channel scan sequencer.
// Assumes a fixed eight-input front end and a 14-bit configuration word.
package chan_scan_pkg;
    localparam int NUM_IN   = 8;
    localparam int CH_W     = $clog2(NUM_IN);
    localparam int CFG_W    = 14;
    localparam int SGL_BIT  = 11;   // 1 = single-ended, 0 = pairs
    localparam int LAST_LSB = 7;    // last-channel field position
    localparam int MODE_LSB = 1;    // 2-bit sequencer mode field

    typedef struct packed {
        logic            single;
        logic [CH_W-1:0] last;
        logic            scan_en;
        logic            temp_en;
    } cfg_t;

    typedef struct packed {
        logic            valid;
        logic            temp;
        logic            pair;
        logic [CH_W-1:0] chan;
    } acq_t;

    // Turn a raw configuration word into the fields the scan uses.
    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        cfg_t       c;
        logic [1:0] mode;
        mode      = w[MODE_LSB +: 2];
        c.single  = w[SGL_BIT];
        c.last    = w[LAST_LSB +: CH_W];
        c.scan_en = (mode == 2'b01) || (mode == 2'b10);
        c.temp_en = (mode == 2'b01);
        return c;
    endfunction
endpackage

// File: rtl/scan_cfg_stage.sv
// Holds the pending and the active configuration. A written word waits as
// pending and becomes active at the next phase strobe. The stage flags a
// restart when the applied word moves the scan definition.
// Assumes phase_stb is a one-cycle pulse.
module scan_cfg_stage
    import chan_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             phase_stb,
    output logic             eff_vld,
    output cfg_t             eff_cfg,
    output logic             restart
);
    logic [CFG_W-1:0] pend_q;
    logic             pend_vld_q;
    cfg_t             act_q;
    logic             act_vld_q;
    cfg_t             pend_dec;
    logic             apply;

    // Decode the pending word and decide whether it lands this cycle.
    always_comb begin
        pend_dec = decode_cfg(pend_q);
        apply    = phase_stb && pend_vld_q;
        eff_cfg  = apply ? pend_dec : act_q;
        eff_vld  = apply || act_vld_q;
        restart  = apply && (!act_vld_q
                             || (pend_dec.single != act_q.single)
                             || (pend_dec.last   != act_q.last)
                             || (pend_dec.scan_en && !act_q.scan_en));
    end

    // Capture written words; drop the pending flag once a strobe applies it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (cfg_wr) begin
            pend_q     <= cfg_word;
            pend_vld_q <= 1'b1;
        end else if (phase_stb) begin
            pend_vld_q <= 1'b0;
        end
    end

    // Promote the pending configuration to active at a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= '0;
            act_vld_q <= 1'b0;
        end else if (apply) begin
            act_q     <= pend_dec;
            act_vld_q <= 1'b1;
        end
    end

    AST_ACTIVE_ONLY_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_stb |=> $stable(act_q) && $stable(act_vld_q)); // R2
endmodule

// File: rtl/scan_next_sel.sv
// Works out the selection for the next phase from the current one and the
// configuration in force at the strobe. Purely combinational.
// Assumes the current channel never lies past the end point unless a restart
// is flagged, which holds because end-point edits always restart.
module scan_next_sel
    import chan_scan_pkg::*;
(
    input  acq_t cur,
    input  logic eff_vld,
    input  cfg_t eff_cfg,
    input  logic restart,
    output acq_t nxt
);
    logic [CH_W-1:0] stop_ch;
    logic [CH_W-1:0] step;
    logic [CH_W-1:0] base_ch;

    // End point and stride depend on single versus pair scanning.
    always_comb begin
        base_ch = {eff_cfg.last[CH_W-1:1], 1'b0};
        stop_ch = eff_cfg.single ? eff_cfg.last : base_ch;
        step    = eff_cfg.single ? CH_W'(1) : CH_W'(2);
    end

    // Choose hold, fixed channel, restart, wrap, temperature slot or step.
    always_comb begin
        nxt = cur;
        if (eff_vld) begin
            nxt.valid = 1'b1;
            nxt.pair  = !eff_cfg.single;
            if (!eff_cfg.scan_en) begin
                nxt.chan = stop_ch;
                nxt.temp = 1'b0;
            end else if (restart || !cur.valid || cur.temp) begin
                nxt.chan = '0;
                nxt.temp = 1'b0;
            end else if (cur.chan >= stop_ch) begin
                nxt.chan = '0;
                nxt.temp = eff_cfg.temp_en;
            end else begin
                nxt.chan = cur.chan + step;
                nxt.temp = 1'b0;
            end
        end
    end
endmodule

// File: rtl/scan_tag_pipe.sv
// Delays the acquisition descriptor by DEPTH phases, so that each converter
// result carries the identity of the input it was sampled from.
// Assumes phase_stb is a one-cycle pulse.
module scan_tag_pipe
    import chan_scan_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_stb,
    input  acq_t din,
    output acq_t dout
);
    acq_t stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        // Each stage moves one place per phase strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else if (phase_stb) begin
                stg[g] <= (g == 0) ? din : stg[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign dout = stg[DEPTH-1];

    if (DEPTH == 1) begin : g_chk
        AST_TAG_ONE_PHASE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
            phase_stb |=> dout == $past(din)); // R8
    end
endmodule

// File: rtl/chan_scan_seq.sv
// Top of the channel scan sequencer. It keeps the current acquisition
// selection, moves it on at each phase strobe, and labels results through
// the tag pipeline. Assumes a one-cycle phase_stb and a reset held low for
// at least one clock edge.
module chan_scan_seq
    import chan_scan_pkg::*;
#(
    parameter int TAG_DELAY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             phase_stb,
    output logic             acq_valid,
    output logic [CH_W-1:0]  acq_chan,
    output logic             acq_pair,
    output logic             acq_temp,
    output logic             tag_valid,
    output logic [CH_W-1:0]  tag_chan,
    output logic             tag_pair,
    output logic             tag_temp
);
    logic eff_vld;
    cfg_t eff_cfg;
    logic restart;
    acq_t acq_q;
    acq_t acq_nxt;
    acq_t tag_q;

    scan_cfg_stage u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_word  (cfg_word),
        .phase_stb (phase_stb),
        .eff_vld   (eff_vld),
        .eff_cfg   (eff_cfg),
        .restart   (restart)
    );

    scan_next_sel u_next (
        .cur     (acq_q),
        .eff_vld (eff_vld),
        .eff_cfg (eff_cfg),
        .restart (restart),
        .nxt     (acq_nxt)
    );

    // Hold the acquisition selection and advance it at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_q <= '0;
        end else if (phase_stb) begin
            acq_q <= acq_nxt;
        end
    end

    scan_tag_pipe #(.DEPTH(TAG_DELAY)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_stb (phase_stb),
        .din       (acq_q),
        .dout      (tag_q)
    );

    assign acq_valid = acq_q.valid;
    assign acq_chan  = acq_q.chan;
    assign acq_pair  = acq_q.pair;
    assign acq_temp  = acq_q.temp;
    assign tag_valid = tag_q.valid;
    assign tag_chan  = tag_q.chan;
    assign tag_pair  = tag_q.pair;
    assign tag_temp  = tag_q.temp;

    AST_HOLD_BETWEEN_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_stb |=> $stable(acq_q) && $stable(tag_q)); // R9
    AST_PAIR_EVEN_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        acq_valid && acq_pair |-> !acq_chan[0]); // R4
    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb && restart && eff_cfg.scan_en |=> acq_valid && acq_chan == '0 && !acq_temp); // R6
    AST_TEMP_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb && eff_vld && !eff_cfg.temp_en |=> !acq_temp); // R5
    AST_FIXED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb && eff_vld && !eff_cfg.scan_en && eff_cfg.single
        |=> acq_chan == $past(eff_cfg.last)); // R7
    AST_SILENT_BEFORE_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb && !eff_vld |=> !acq_valid && !tag_valid); // R1
endmodule

// File: tb/chan_scan_seq_bench.sv
module chan_scan_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [13:0] cfg_word;
    logic        phase_stb;
    logic        acq_valid, acq_pair, acq_temp;
    logic [2:0]  acq_chan;
    logic        tag_valid, tag_pair, tag_temp;
    logic [2:0]  tag_chan;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    bit       m_v, m_p, m_t, t_v, t_p, t_t, act_v, pend_v;
    bit [2:0] m_c, t_c;
    bit [13:0] act_w, pend_w;

    always #2 clk = ~clk;

    chan_scan_seq u_chan_scan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .phase_stb(phase_stb), .acq_valid(acq_valid), .acq_chan(acq_chan),
        .acq_pair(acq_pair), .acq_temp(acq_temp), .tag_valid(tag_valid),
        .tag_chan(tag_chan), .tag_pair(tag_pair), .tag_temp(tag_temp)
    );

    function automatic bit f_en(input bit [13:0] w);
        return (w[2:1] == 2'b01) || (w[2:1] == 2'b10);
    endfunction

    function automatic bit [13:0] mk(input bit sgl, input bit [2:0] last, input bit [1:0] mode);
        return (14'(sgl) << 11) | (14'(last) << 7) | (14'(mode) << 1);
    endfunction

    task automatic model_edge(input bit stb, input bit wr, input bit [13:0] w);
        bit rs;
        bit [2:0] stop;
        if (stb) begin
            t_v = m_v; t_c = m_c; t_p = m_p; t_t = m_t;
            rs = 0;
            if (pend_v) begin
                rs = !act_v || (pend_w[11] != act_w[11]) || (pend_w[9:7] != act_w[9:7])
                     || (f_en(pend_w) && !f_en(act_w));
                act_w = pend_w; act_v = 1;
            end
            if (act_v) begin
                stop = act_w[11] ? act_w[9:7] : (act_w[9:7] & 3'b110);
                m_p  = !act_w[11];
                if (!f_en(act_w)) begin m_c = stop; m_t = 0; end
                else if (rs || !m_v || m_t) begin m_c = 0; m_t = 0; end
                else if (m_c >= stop) begin m_c = 0; m_t = (act_w[2:1] == 2'b01); end
                else m_c = m_c + (act_w[11] ? 3'd1 : 3'd2);
                m_v = 1;
            end
        end
        if (wr) begin pend_w = w; pend_v = 1; end
        else if (stb) pend_v = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req);
        chk(req, {acq_valid, tag_valid}, {m_v, t_v});
        if (m_v) chk(req, {acq_chan, acq_pair, acq_temp}, {m_c, m_p, m_t});
        if (t_v) chk(req, {tag_chan, tag_pair, tag_temp}, {t_c, t_p, t_t});
    endtask

    // one clock: drive at falling edge, sample at the next falling edge
    task automatic step(input bit stb, input bit wr, input bit [13:0] w, input string req);
        phase_stb = stb; cfg_wr = wr; cfg_word = w;
        model_edge(stb, wr, w);
        @(negedge clk);
        phase_stb = 0; cfg_wr = 0;
        chk_out(req);
    endtask

    task automatic expect_acq(input bit [2:0] c, input bit t, input string req);
        step(1, 0, 14'h0, req);
        chk(req, {acq_chan, acq_temp}, {c, t});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        rst_n = 0; cfg_wr = 0; cfg_word = '0; phase_stb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state and strobes with no configuration
        chk_out("R1 reset");
        step(1, 0, 14'h0, "R1 no config");
        step(1, 0, 14'h0, "R1 no config");
        // R2: write between strobes changes nothing
        step(0, 1, mk(1, 3'd7, 2'b01), "R2 pending");
        step(0, 0, 14'h0, "R2 pending");
        // R3/R5: single pass with temperature
        expect_acq(3'd0, 0, "R2 apply");
        chk("R8 tag lag", tag_valid, 0);
        for (int i = 1; i < 8; i++) expect_acq(3'(i), 0, "R3 single order");
        chk("R8 tag", tag_chan, 6);
        expect_acq(3'd0, 1, "R5 temp slot");
        expect_acq(3'd0, 0, "R5 wrap");
        // R4: pairs, last field 7
        step(0, 1, mk(0, 3'd7, 2'b01), "R4 write");
        expect_acq(3'd0, 0, "R6 restart pair");
        chk("R4 pair flag", acq_pair, 1);
        expect_acq(3'd2, 0, "R4 pair order");
        expect_acq(3'd4, 0, "R4 pair order");
        expect_acq(3'd6, 0, "R4 pair order");
        expect_acq(3'd0, 1, "R4 temp after pairs");
        // R4/R6: last field 6 restarts, scans same four pairs
        step(0, 1, mk(0, 3'd6, 2'b01), "R6 write");
        expect_acq(3'd0, 0, "R6 restart last");
        expect_acq(3'd2, 0, "R4 last 6");
        // R6: mode 01 -> 10 does not restart; R5 no temp slot
        step(0, 1, mk(0, 3'd6, 2'b10), "R6 write");
        expect_acq(3'd4, 0, "R6 no restart");
        expect_acq(3'd6, 0, "R6 no restart");
        expect_acq(3'd0, 0, "R5 no temp");
        // R6: other bits do not restart
        step(0, 1, mk(0, 3'd6, 2'b10) | 14'h2001, "R6 write");
        expect_acq(3'd2, 0, "R6 other bits");
        // R7: sequencer off
        step(0, 1, mk(1, 3'd5, 2'b00), "R7 write");
        expect_acq(3'd5, 0, "R7 fixed single");
        expect_acq(3'd5, 0, "R7 fixed hold");
        step(0, 1, mk(0, 3'd5, 2'b11), "R7 write");
        expect_acq(3'd4, 0, "R7 fixed pair");
        // R2: write in the same cycle as a strobe waits one phase
        step(1, 1, mk(1, 3'd3, 2'b01), "R2 same cycle");
        chk("R2 same cycle", acq_chan, 4);
        expect_acq(3'd0, 0, "R6 switch on restart");
        expect_acq(3'd1, 0, "R3 after switch on");
        // random phases
        for (int n = 0; n < 2500; n++) begin
            int idle;
            idle = int'($urandom_range(0, 2));
            for (int k = 0; k < idle; k++) begin
                bit [13:0] w;
                w = 14'($urandom);
                if ($urandom_range(0, 3) != 0) w[2:1] = 2'($urandom_range(1, 2));
                step(0, ($urandom_range(0, 9) == 0), w, "R9 between phases");
            end
            begin
                bit [13:0] w;
                w = 14'($urandom);
                if ($urandom_range(0, 3) != 0) w[2:1] = 2'($urandom_range(1, 2));
                step(1, ($urandom_range(0, 15) == 0), w, "R3 R4 R5 R6 R8 random");
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule